// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches an 8-pin general-purpose port (the pin count is a parameter) and turns activity on each pin into interrupt status. Every pin picks its own trigger: it can be sensed as a level (active high or active low) or as an edge (rising only, falling only, or both). Pins sensed by edge keep a sticky event bit until software clears it. Pins sensed by level report the live input and nothing more, so their status drops as soon as the input returns to its idle level.

Software programs and inspects the block over a simple byte-wide register bus. A write takes effect on the clock edge that samples it, and a read returns its data in the same cycle. Three configuration registers pick the trigger type, an enable register masks each pin, two read-only views give raw and masked status, and a write-only register clears latched edge events. The masked status bits are ORed into a single interrupt line. The pin inputs must already be synchronized to `clk`.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the trigger-select, dual-edge, polarity and enable registers are 0, every edge event latch is 0, and `irq_out` is 0. Reset is asynchronous and active low.
- R2: The trigger-select register sits at offset 0x404, and a 1 in bit i makes pin i level sensed. If the polarity bit (register 0x40C) is 1, raw status bit i equals the pin level in the same cycle, without latching.
- R3: For a level-sensed pin whose polarity bit is 0, raw status bit i is the inverse of the pin level in the same cycle.
- R4: An edge-sensed pin (trigger-select bit 0) with dual-edge bit 0 (register 0x408) and polarity bit 1 sets its event latch on a 0-to-1 change. The change is seen by comparing the pin with its value one clock earlier. Raw status shows the latch from the next cycle on, and the latch stays set after the pin falls back.
- R5: An edge-sensed pin with dual-edge bit 0 and polarity bit 0 latches on a 1-to-0 change only.
- R6: An edge-sensed pin whose dual-edge bit is 1 latches on both changes, and its polarity bit has no effect. For a level-sensed pin the dual-edge bit has no effect.
- R7: Writing to offset 0x41C clears the event latch of every pin whose data bit is 1, starting with the next cycle. Pins whose data bit is 0 keep their latch.
- R8: If a clear and a newly detected edge hit the same pin in the same cycle, the latch ends up set.
- R9: The enable register sits at offset 0x410. The masked status, read at offset 0x418, is raw status AND enable. `irq_out` is the OR of all masked status bits, in the same cycle.
- R10: Raw status at 0x414 and masked status at 0x418 cannot be written, and writes to them change nothing. The clear register at 0x41C always reads as 0.
- R11: The registers at 0x404, 0x408, 0x40C and 0x410 read back the last value written to them. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | PINS | Synchronized pin levels |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | PINS | Write data, one bit per pin |
| bus_rdata | output | PINS | Read data, valid in the access cycle |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Two things can reach an edge event latch in the same clock: a software clear and a fresh pin edge. The bench sets the latch with a rising edge and brings the pin back low, which leaves the latch set. In a single cycle it then drives the pin high and writes all ones to the clear offset. The raw status read after that edge must show the latch still set, and a checker property asserts the same for any cycle in which a clear and a detected edge coincide.

// File: rtl/gid_pkg.sv
`timescale 1ns/1ps
package gid_pkg;
  localparam int unsigned ADDR_W = 12;

  // Byte offsets, kept where software decodes them
  localparam logic [ADDR_W-1:0] OFS_TRIG = 12'h404;
  localparam logic [ADDR_W-1:0] OFS_DUAL = 12'h408;
  localparam logic [ADDR_W-1:0] OFS_POL  = 12'h40C;
  localparam logic [ADDR_W-1:0] OFS_EN   = 12'h410;
  localparam logic [ADDR_W-1:0] OFS_RAW  = 12'h414;
  localparam logic [ADDR_W-1:0] OFS_MSK  = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 12'h41C;

  localparam int unsigned NUM_CFG = 4;

  typedef enum logic [1:0] {
    CFG_TRIG = 2'd0,
    CFG_DUAL = 2'd1,
    CFG_POL  = 2'd2,
    CFG_EN   = 2'd3
  } cfg_idx_e;

  // Offset of configuration word k (word-spaced from the first)
  function automatic logic [ADDR_W-1:0] cfg_offset(input int unsigned k);
    return OFS_TRIG + ADDR_W'(4 * k);
  endfunction

  // Edge hit for one pin given current and previous samples
  function automatic logic edge_seen(input logic cur, input logic prev,
                                     input logic dual, input logic rise_sel);
    logic up;
    logic dn;
    up = cur & ~prev;
    dn = ~cur & prev;
    if (dual) return up | dn;
    return rise_sel ? up : dn;
  endfunction

  // Level activity for one pin: active when it matches the polarity
  function automatic logic level_active(input logic cur, input logic hi_sel);
    return ~(cur ^ hi_sel);
  endfunction
endpackage

// File: rtl/gid_cfg_regs.sv
`timescale 1ns/1ps
module gid_cfg_regs
  import gid_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   trig_q,
  output logic [PINS-1:0]   dual_q,
  output logic [PINS-1:0]   pol_q,
  output logic [PINS-1:0]   en_q,
  output logic [PINS-1:0]   clr_pls
);
  logic [PINS-1:0] cfg_q [NUM_CFG];

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
    logic hit;
    assign hit = wr_stb && (addr == cfg_offset(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cfg_q[k] <= '0;
      else if (hit) cfg_q[k] <= wdata;
    end
  end

  assign trig_q = cfg_q[CFG_TRIG];
  assign dual_q = cfg_q[CFG_DUAL];
  assign pol_q  = cfg_q[CFG_POL];
  assign en_q   = cfg_q[CFG_EN];

  // One-cycle clear strobe, never stored
  assign clr_pls = (wr_stb && (addr == OFS_CLR)) ? wdata : '0;
endmodule

// File: rtl/gid_pin_detect.sv
`timescale 1ns/1ps
module gid_pin_detect
  import gid_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] trig_q,
  input  logic [PINS-1:0] dual_q,
  input  logic [PINS-1:0] pol_q,
  input  logic [PINS-1:0] clr_pls,
  output logic [PINS-1:0] edge_hit,
  output logic [PINS-1:0] latch_q,
  output logic [PINS-1:0] raw_stat
);
  logic [PINS-1:0] prev_q;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic lvl_act;
    logic set_now;

    assign edge_hit[i] = edge_seen(pin_in[i], prev_q[i], dual_q[i], pol_q[i]);
    assign lvl_act     = level_active(pin_in[i], pol_q[i]);
    assign set_now     = edge_hit[i] & ~trig_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i]  <= 1'b0;
        latch_q[i] <= 1'b0;
      end else begin
        prev_q[i]  <= pin_in[i];
        // A fresh edge outranks a clear in the same cycle
        latch_q[i] <= (latch_q[i] & ~clr_pls[i]) | set_now;
      end
    end

    assign raw_stat[i] = trig_q[i] ? lvl_act : latch_q[i];
  end
endmodule

// File: rtl/gid_read_mux.sv
`timescale 1ns/1ps
module gid_read_mux
  import gid_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   trig_q,
  input  logic [PINS-1:0]   dual_q,
  input  logic [PINS-1:0]   pol_q,
  input  logic [PINS-1:0]   en_q,
  input  logic [PINS-1:0]   raw_stat,
  input  logic [PINS-1:0]   msk_stat,
  output logic [PINS-1:0]   rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        OFS_TRIG: rdata = trig_q;
        OFS_DUAL: rdata = dual_q;
        OFS_POL:  rdata = pol_q;
        OFS_EN:   rdata = en_q;
        OFS_RAW:  rdata = raw_stat;
        OFS_MSK:  rdata = msk_stat;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gid_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pin_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  output logic              irq_out
);
  logic            wr_stb;
  logic            rd_en;
  logic [PINS-1:0] trig_q;
  logic [PINS-1:0] dual_q;
  logic [PINS-1:0] pol_q;
  logic [PINS-1:0] en_q;
  logic [PINS-1:0] clr_pls;
  logic [PINS-1:0] edge_hit;
  logic [PINS-1:0] latch_q;
  logic [PINS-1:0] raw_stat;
  logic [PINS-1:0] msk_stat;

  assign wr_stb = bus_sel & bus_wr;
  assign rd_en  = bus_sel & ~bus_wr;

  gid_cfg_regs #(.PINS(PINS)) cfg_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .trig_q (trig_q),
    .dual_q (dual_q),
    .pol_q  (pol_q),
    .en_q   (en_q),
    .clr_pls(clr_pls)
  );

  gid_pin_detect #(.PINS(PINS)) det_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .trig_q  (trig_q),
    .dual_q  (dual_q),
    .pol_q   (pol_q),
    .clr_pls (clr_pls),
    .edge_hit(edge_hit),
    .latch_q (latch_q),
    .raw_stat(raw_stat)
  );

  assign msk_stat = raw_stat & en_q;
  assign irq_out  = |msk_stat;

  gid_read_mux #(.PINS(PINS)) rd_i (
    .rd_en   (rd_en),
    .addr    (bus_addr),
    .trig_q  (trig_q),
    .dual_q  (dual_q),
    .pol_q   (pol_q),
    .en_q    (en_q),
    .raw_stat(raw_stat),
    .msk_stat(msk_stat),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/gid_checker.sv
`timescale 1ns/1ps
module gid_checker
  import gid_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PINS-1:0]   bus_rdata,
  input logic [PINS-1:0]   trig_q,
  input logic [PINS-1:0]   en_q,
  input logic [PINS-1:0]   edge_hit,
  input logic [PINS-1:0]   clr_pls,
  input logic [PINS-1:0]   latch_q,
  input logic [PINS-1:0]   raw_stat,
  input logic              irq_out
);
  // R9
  irq_combine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |(raw_stat & en_q));

  // R8
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit & ~trig_q) != '0) |=>
      ((latch_q & $past(edge_hit & ~trig_q)) == $past(edge_hit & ~trig_q)));

  // R4
  latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(latch_q & ~clr_pls) & ~latch_q) == '0));

  // R7
  latch_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_pls & ~edge_hit) != '0) |=> ((latch_q & $past(clr_pls & ~edge_hit)) == '0));

  // R5
  latch_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(edge_hit & ~trig_q)) == '0));

  // R10
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == OFS_CLR) |-> (bus_rdata == '0));
endmodule

bind gpio_irq_detect gid_checker #(.PINS(PINS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .trig_q   (trig_q),
  .en_q     (en_q),
  .edge_hit (edge_hit),
  .clr_pls  (clr_pls),
  .latch_q  (latch_q),
  .raw_stat (raw_stat),
  .irq_out  (irq_out)
);

// File: tb/gpio_irq_detect_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb_top;
  localparam int PINS = 8;
  localparam logic [11:0] A_TRIG = 12'h404;
  localparam logic [11:0] A_DUAL = 12'h408;
  localparam logic [11:0] A_POL  = 12'h40C;
  localparam logic [11:0] A_EN   = 12'h410;
  localparam logic [11:0] A_RAW  = 12'h414;
  localparam logic [11:0] A_MSK  = 12'h418;
  localparam logic [11:0] A_CLR  = 12'h41C;

  // {trig, dual, pol, exp_idle, exp_after_rise, exp_after_fall}
  localparam int NVEC = 7;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b101_010,  // level, active high
    6'b100_101,  // level, active low
    6'b111_010,  // level, active high, dual bit set but ignored
    6'b001_011,  // rising edge
    6'b000_001,  // falling edge
    6'b010_011,  // both edges, polarity 0
    6'b011_011   // both edges, polarity 1
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PINS-1:0] pin_in = '0;
  logic            bus_sel = 1'b0;
  logic            bus_wr = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [PINS-1:0] bus_wdata = '0;
  logic [PINS-1:0] bus_rdata;
  logic            irq_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_detect #(.PINS(PINS)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [PINS-1:0] d);
    tick();
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // Called just after an edge; samples mid-cycle
  task automatic read_check(input logic [11:0] a, input logic [PINS-1:0] exp, input string req);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #4;
    check(req, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic irq_check(input logic exp, input string req);
    #1;
    check(req, irq_out, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    read_check(A_TRIG, 8'h00, "R1");
    read_check(A_DUAL, 8'h00, "R1");
    read_check(A_POL,  8'h00, "R1");
    read_check(A_EN,   8'h00, "R1");
    read_check(A_RAW,  8'h00, "R1");
    irq_check(1'b0, "R1");

    // Table walk over trigger types
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      logic [5:0] e;
      e = VEC[v];
      if (e[5])      tag = e[3] ? "R2" : "R3";
      else if (e[4]) tag = "R6";
      else           tag = e[3] ? "R4" : "R5";
      bus_write(A_TRIG, {PINS{e[5]}});
      bus_write(A_DUAL, {PINS{e[4]}});
      bus_write(A_POL,  {PINS{e[3]}});
      bus_write(A_EN,   '1);
      pin_in = '0;
      tick();
      bus_write(A_CLR, '1);
      read_check(A_RAW, {PINS{e[2]}}, tag);
      irq_check(e[2], tag);
      pin_in = '1;
      tick();
      read_check(A_RAW, {PINS{e[1]}}, tag);
      read_check(A_MSK, {PINS{e[1]}}, tag);
      pin_in = '0;
      tick();
      read_check(A_RAW, {PINS{e[0]}}, tag);
      irq_check(e[0], tag);
    end

    // Mixed per-pin modes: pins 0-3 level, 4-5 both edges, 6-7 falling
    bus_write(A_TRIG, 8'h0F);
    bus_write(A_DUAL, 8'h30);
    bus_write(A_POL,  8'h05);
    bus_write(A_CLR,  8'hFF);
    read_check(A_RAW, 8'h0A, "R3");
    pin_in = 8'hFF;
    tick();
    read_check(A_RAW, 8'h35, "R2");
    pin_in = 8'h00;
    tick();
    read_check(A_RAW, 8'hFA, "R6");

    // R11 readback and unmapped offset
    bus_write(A_TRIG, 8'hA5);
    bus_write(A_DUAL, 8'h3C);
    bus_write(A_POL,  8'h96);
    bus_write(A_EN,   8'h81);
    read_check(A_TRIG, 8'hA5, "R11");
    read_check(A_DUAL, 8'h3C, "R11");
    read_check(A_POL,  8'h96, "R11");
    read_check(A_EN,   8'h81, "R11");
    read_check(12'h400, 8'h00, "R11");

    // Rising mode on all pins, latch everything
    bus_write(A_TRIG, 8'h00);
    bus_write(A_DUAL, 8'h00);
    bus_write(A_POL,  8'hFF);
    bus_write(A_EN,   8'h00);
    bus_write(A_CLR,  8'hFF);
    pin_in = 8'hFF;
    tick();
    read_check(A_RAW, 8'hFF, "R4");
    irq_check(1'b0, "R9");

    // R10 status views are read-only, clear reads 0
    bus_write(A_RAW, 8'h00);
    read_check(A_RAW, 8'hFF, "R10");
    bus_write(A_MSK, 8'hFF);
    read_check(A_MSK, 8'h00, "R10");
    read_check(A_CLR, 8'h00, "R10");

    // R9 masking
    bus_write(A_EN, 8'h05);
    read_check(A_MSK, 8'h05, "R9");
    irq_check(1'b1, "R9");

    // R7 partial clear, zero bits untouched
    bus_write(A_CLR, 8'h0F);
    read_check(A_RAW, 8'hF0, "R7");
    irq_check(1'b0, "R9");
    bus_write(A_CLR, 8'h00);
    read_check(A_RAW, 8'hF0, "R7");

    // R8 clear and new rising edge in the same cycle
    pin_in = 8'h00;
    tick();
    read_check(A_RAW, 8'hF0, "R4");
    tick();
    pin_in = 8'hFF;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 8'hFF;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0;
    read_check(A_RAW, 8'hFF, "R8");

    // R1 reset in mid-run
    pin_in = 8'h00;
    tick();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    read_check(A_POL, 8'h00, "R1");
    read_check(A_EN,  8'h00, "R1");
    read_check(A_RAW, 8'h00, "R1");
    irq_check(1'b0, "R1");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule